// File: doc/BRIEF.md
# Stopwatch Elapsed-Time Counter

This block keeps the elapsed time of a stopwatch as four decimal digits: tenths of a second, seconds units, seconds tens and minutes units. An external timer supplies a single-cycle tick ten times per second. The tick advances the count only while an internal run flag is set. Two push-button inputs control that flag in the manner of a set/reset latch: start sets it and stop clears it.

The digits form a ripple chain of modulo counters. Three stages count modulo 10 and the seconds-tens stage counts modulo 6, so the display runs from 0:00.0 up to 9:59.9 and then wraps. Each stage hands its increment on to the next through a one-cycle rollover pulse. The last stage's rollover leaves the block as a wrap indication. A synchronous reset clears the digits and the run flag and touches nothing else, so a display driver attached to the outputs keeps refreshing.

Top module: `stopwatch_time_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, all four digits become 0 and the run flag is cleared, so ticks that follow reset do not advance the count until start is pressed again.
- R2: With the run flag set, each cycle with `tick_i` high advances the tenths digit by one at the next rising edge.
- R3: Ticks that arrive while the run flag is clear leave every digit unchanged.
- R4: A cycle with `stop_i` high clears the run flag at the next edge, and the digits then hold their value.
- R5: When `start_i` and `stop_i` are high in the same cycle, the run flag ends up clear.
- R6: The tenths and seconds-units digits count 0 to 9. An increment at 9 returns the digit to 0 and increments the next digit in the same edge.
- R7: The seconds-tens digit counts 0 to 5. An increment at 5 returns it to 0 and increments the minutes digit in the same edge.
- R8: A stage's rollover is high only in a cycle where its increment is high and its digit holds its terminal value (9, or 5 for seconds tens). It is never high for two edges in a row caused by one tick.
- R9: The minutes digit wraps from 9 to 0. `wrap_o` is high, combinationally, during the enabled tick cycle in which the displayed time is 9:59.9, and the next edge shows 0:00.0.
- R10: In cycles without an enabled tick, no digit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of digits and run flag |
| tick_i | input | 1 | One-cycle 10 Hz time pulse |
| start_i | input | 1 | Sets the run flag |
| stop_i | input | 1 | Clears the run flag; wins over start |
| tenths_o | output | DIGIT_W (4) | Tenths of seconds, BCD |
| sec_ones_o | output | DIGIT_W (4) | Seconds units, BCD |
| sec_tens_o | output | DIGIT_W (4) | Seconds tens, BCD 0..5 |
| min_ones_o | output | DIGIT_W (4) | Minutes units, BCD |
| wrap_o | output | 1 | Rollover of the minutes stage |

## Verification
The count is driven with a tick in every cycle, with ticks separated by idle cycles, and with ticks while the flag is clear, after stop, and after a simultaneous start and stop press. Idle gaps distinguish a tick-gated counter from one that advances every cycle. The flag-clear cases show whether the latch and its stop priority really gate the enable. A full run through all 6000 states checks every carry boundary, the modulo-6 stage in particular, and shows that `wrap_o` rises only at 9:59.9. A reset in the middle of a run shows that both the digits and the run flag are cleared.

// File: rtl/sw_count_pkg.sv
package sw_count_pkg;

  // Next value of a modulo counter after one increment.
  function automatic int unsigned wrap_inc(input int unsigned cur, input int unsigned modulus);
    if (cur + 1 >= modulus) return 0;
    return cur + 1;
  endfunction

  // True when the next increment carries into the following stage.
  function automatic logic at_terminal(input int unsigned cur, input int unsigned modulus);
    return (cur == modulus - 1);
  endfunction

endpackage

// File: rtl/sw_run_flag.sv
module sw_run_flag (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic stop_i,
  output logic run_o
);

  logic run_q;

  // Stop has priority over start; reset has priority over both.
  always_ff @(posedge clk) begin
    if (rst)          run_q <= 1'b0;
    else if (stop_i)  run_q <= 1'b0;
    else if (start_i) run_q <= 1'b1;
  end

  assign run_o = run_q;

  // R1
  reset_clears_run_chk: assert property (@(posedge clk) rst |=> !run_o);

  // R4
  stop_clears_run_chk: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> !run_o);

  // R5
  stop_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && stop_i) |=> !run_o);

endmodule

// File: rtl/sw_digit_stage.sv
module sw_digit_stage
  import sw_count_pkg::*;
#(
  parameter int unsigned MODULUS = 10,
  parameter int unsigned DIGIT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inc_i,
  output logic [DIGIT_W-1:0] digit_o,
  output logic               roll_o
);

  logic [DIGIT_W-1:0] digit_q;
  logic [DIGIT_W-1:0] digit_next;
  logic               at_top;

  assign at_top     = at_terminal(32'(digit_q), MODULUS);
  assign digit_next = DIGIT_W'(wrap_inc(32'(digit_q), MODULUS));
  assign roll_o     = inc_i & at_top;
  assign digit_o    = digit_q;

  always_ff @(posedge clk) begin
    if (rst)        digit_q <= '0;
    else if (inc_i) digit_q <= digit_next;
  end

  // R6
  digit_range_chk: assert property (@(posedge clk) disable iff (rst)
    32'(digit_o) < MODULUS);

  // R2
  step_by_one_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !roll_o) |=> (digit_o == $past(digit_o) + DIGIT_W'(1)));

  // R8
  roll_wraps_chk: assert property (@(posedge clk) disable iff (rst)
    roll_o |=> (digit_o == '0));

  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !inc_i |=> $stable(digit_o));

endmodule

// File: rtl/stopwatch_time_counter.sv
module stopwatch_time_counter #(
  parameter int unsigned DIGIT_W      = 4,
  parameter int unsigned TENTHS_MOD   = 10,
  parameter int unsigned SEC_ONES_MOD = 10,
  parameter int unsigned SEC_TENS_MOD = 6,
  parameter int unsigned MIN_ONES_MOD = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_i,
  input  logic               start_i,
  input  logic               stop_i,
  output logic [DIGIT_W-1:0] tenths_o,
  output logic [DIGIT_W-1:0] sec_ones_o,
  output logic [DIGIT_W-1:0] sec_tens_o,
  output logic [DIGIT_W-1:0] min_ones_o,
  output logic               wrap_o
);

  localparam int unsigned NUM_STAGES = 4;

  logic                run_w;
  logic                count_en;
  logic [NUM_STAGES:0] carry_w;
  logic [DIGIT_W-1:0]  digit_w [NUM_STAGES];

  sw_run_flag u_run (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .stop_i  (stop_i),
    .run_o   (run_w)
  );

  assign count_en   = tick_i & run_w;
  assign carry_w[0] = count_en;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    localparam int unsigned MOD_G = (g == 0) ? TENTHS_MOD   :
                                    (g == 1) ? SEC_ONES_MOD :
                                    (g == 2) ? SEC_TENS_MOD : MIN_ONES_MOD;
    sw_digit_stage #(
      .MODULUS (MOD_G),
      .DIGIT_W (DIGIT_W)
    ) u_stage (
      .clk     (clk),
      .rst     (rst),
      .inc_i   (carry_w[g]),
      .digit_o (digit_w[g]),
      .roll_o  (carry_w[g+1])
    );
  end

  assign tenths_o   = digit_w[0];
  assign sec_ones_o = digit_w[1];
  assign sec_tens_o = digit_w[2];
  assign min_ones_o = digit_w[3];
  assign wrap_o     = carry_w[NUM_STAGES];

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (tenths_o == '0 && sec_ones_o == '0 && sec_tens_o == '0 && min_ones_o == '0));

  // R3
  idle_flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !run_w |=> ($stable(tenths_o) && $stable(sec_ones_o) && $stable(sec_tens_o) && $stable(min_ones_o)));

  // R9
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (tenths_o == '0 && sec_ones_o == '0 && sec_tens_o == '0 && min_ones_o == '0));

  // R8
  wrap_single_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> !wrap_o);

endmodule

// File: tb/stopwatch_time_counter_tb.sv
module stopwatch_time_counter_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, tick = 1'b0, start = 1'b0, stop = 1'b0;
  logic [3:0] tenths, s_ones, s_tens, m_ones;
  logic wrap;

  stopwatch_time_counter dut_i (
    .clk(clk), .rst(rst), .tick_i(tick), .start_i(start), .stop_i(stop),
    .tenths_o(tenths), .sec_ones_o(s_ones), .sec_tens_o(s_tens),
    .min_ones_o(m_ones), .wrap_o(wrap)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model: elapsed tenths since reset, modulo 10*10*6*10.
  int m_total = 0;
  bit m_run   = 0;

  typedef struct { int total; string tag; } exp_t;
  exp_t sb_q[$];

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int pack_time(input int t);
    return ((t / 600) % 10) * 1000 + ((t / 100) % 6) * 100 + ((t / 10) % 10) * 10 + (t % 10);
  endfunction

  // Driver: apply one cycle of stimulus, check the combinational wrap, queue the expected digits.
  task automatic step(input bit r, input bit t, input bit s, input bit p, input string tag);
    bit en;
    bit exp_wrap;
    exp_t item;
    @(negedge clk);
    rst = r; tick = t; start = s; stop = p;
    #1;
    en       = !r && t && m_run;
    exp_wrap = en && (m_total == 5999);
    if (!r) check(exp_wrap ? "R9" : "R8", int'(wrap), int'(exp_wrap), "wrap");
    if (r) begin
      m_total = 0;
      m_run   = 0;
    end else begin
      if (en) m_total = (m_total + 1) % 6000;
      if (p)      m_run = 0;
      else if (s) m_run = 1;
    end
    item.total = m_total;
    item.tag   = tag;
    sb_q.push_back(item);
  endtask

  // Monitor: after each edge, compare the digits against the oldest queued expectation.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        int act;
        e   = sb_q.pop_front();
        act = int'(m_ones) * 1000 + int'(s_tens) * 100 + int'(s_ones) * 10 + int'(tenths);
        check(e.tag, act, pack_time(e.total), "digits");
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, "R1");
    // R3 ticks while the flag is clear
    for (int i = 0; i < 5; i++) step(0, 1, 0, 0, "R3");
    // R2 start, then ticks separated by idle cycles (R10), crossing tenths wraps (R6)
    step(0, 0, 1, 0, "R2");
    for (int i = 0; i < 25; i++) begin
      step(0, 1, 0, 0, (m_total % 10 == 9) ? "R6" : "R2");
      step(0, 0, 0, 0, "R10");
    end
    // R4 stop then ticks
    step(0, 0, 0, 1, "R4");
    for (int i = 0; i < 5; i++) step(0, 1, 0, 0, "R4");
    // R5 simultaneous start and stop
    step(0, 0, 1, 1, "R5");
    for (int i = 0; i < 5; i++) step(0, 1, 0, 0, "R5");
    // Full run through the wrap: R7 at seconds-tens carries, R9 at the top
    step(0, 0, 1, 0, "R2");
    for (int i = 0; i < 5980; i++) begin
      string tg;
      if (m_total == 5999)           tg = "R9";
      else if (m_total % 600 == 599) tg = "R7";
      else if (m_total % 10 == 9)    tg = "R6";
      else                           tg = "R2";
      step(0, 1, 0, 0, tg);
    end
    // R1 reset mid-run clears digits and the run flag
    step(1, 1, 0, 0, "R1");
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, "R1");
    repeat (2) @(posedge clk);
    #3;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule